// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block decides, for a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, write-back), where each ALU operand of the instruction now in execute comes from. It compares the two source register numbers of that instruction against the destinations recorded in the execute/memory and memory/write-back pipeline registers. It then drives one select per operand that picks the register file value, the newer in-flight result, or the older one. Only read-after-write dependences are handled. Reads happen in decode and writes happen in write-back, always in order, so write-after-read and write-after-write cases cannot arise.

The block also finds a load in execute whose result the instruction in decode needs. In that case it raises a hold for the PC and the fetch/decode register, and a bubble request for the decode/execute register. The pipeline owner turns the bubble into cleared write, store and load flags. One exception avoids a stall: a store in decode that needs the loaded register only as its store data. That value is supplied later, in the memory stage, through a dedicated store-data select taken from write-back.

All outputs are combinational functions of the current inputs. The register file is assumed to write in the first half-cycle and read in the second, so no write-back-to-decode path is needed.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register file value, 2'b10 for the execute/memory result and 2'b01 for the memory/write-back result; 2'b11 is never driven.
- R2: An operand selects 2'b10 when its source number equals the execute/memory destination, that stage's write enable is high, it is not a load, and the destination is not register 0.
- R3: An operand selects 2'b01 when the memory/write-back stage writes a nonzero destination equal to its source and the execute/memory stage does not match (match means write enable high, nonzero destination, equal number).
- R4: When the execute/memory stage matches, it wins over memory/write-back. If that matching entry is a load, the select is 2'b00, because the older write-back value would be stale.
- R5: Register 0 is never forwarded, never causes a stall and never drives the store-data select. A disabled write is never forwarded either.
- R6: The two operand selects are computed independently and may differ in the same cycle.
- R7: hold_front and bubble_idex are both high when execute holds a load that writes a nonzero register, and the decode instruction reads that register through an operand it uses.
- R8: No hold or bubble is raised when the matching decode source is marked unused, when execute is not a load, or when the load's write enable is low.
- R9: A store in decode whose only dependence on the execute load is its store-data source (source b) raises no stall. A dependence through its address source (source a) does stall.
- R10: store_fwd_wb is high when memory holds a store, and write-back writes a nonzero register equal to that store's data source number.
- R11: All outputs follow input changes within the same cycle, with no register inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | AW | Decode-stage first source register number |
| id_src_b | input | AW | Decode-stage second source register number (store data for stores) |
| id_use_a | input | 1 | Decode instruction actually reads source a |
| id_use_b | input | 1 | Decode instruction actually reads source b |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_src_a | input | AW | Execute-stage first source register number |
| ex_src_b | input | AW | Execute-stage second source register number |
| ex_dst | input | AW | Execute-stage destination register number |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | AW | Execute/memory register destination number |
| mem_wr_en | input | 1 | Execute/memory register write enable |
| mem_is_load | input | 1 | Execute/memory instruction is a load |
| mem_is_store | input | 1 | Execute/memory instruction is a store |
| mem_src_b | input | AW | Store-data source register number of the memory-stage instruction |
| wb_dst | input | AW | Memory/write-back register destination number |
| wb_wr_en | input | 1 | Memory/write-back register write enable |
| fwd_sel_a | output | 2 | Operand a source select |
| fwd_sel_b | output | 2 | Operand b source select |
| store_fwd_wb | output | 1 | Memory-stage store data taken from the write-back value |
| hold_front | output | 1 | Hold PC and the fetch/decode register |
| bubble_idex | output | 1 | Insert a bubble into the decode/execute register |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register sits between the inputs and the outputs. The bench applies each input pattern on the falling clock edge and samples all outputs a few nanoseconds later, well before the next rising edge. No value is ever carried across an edge. Each scenario first drives an idle pattern, so one case cannot leave a stale match for the next one.

// File: rtl/fwd_hazard_pkg.sv
// Shared encodings for the forwarding and hazard logic.
// Assumes a 2-bit operand select in front of each ALU input.
package fwd_hazard_pkg;
    typedef enum logic [1:0] {
        OPSEL_RF  = 2'b00,
        OPSEL_WB  = 2'b01,
        OPSEL_MEM = 2'b10
    } opsel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
// Chooses the source of one ALU operand in execute.
// Assumes register 0 is hard-wired zero and the newest producer wins.
// A matching load in execute/memory blocks forwarding, because its data is not ready yet.
module fwd_operand_sel
    import fwd_hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_en,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_en,
    output logic [1:0]    sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    // Match of this source against each in-flight destination.
    always_comb begin
        mem_hit = mem_wr_en && (mem_dst != ZERO_REG) && (mem_dst == src);
        wb_hit  = wb_wr_en  && (wb_dst  != ZERO_REG) && (wb_dst  == src);
    end

    // Priority pick: the newer stage first; a pending load falls back to the file.
    always_comb begin
        if (mem_hit)
            sel = mem_is_load ? OPSEL_RF : OPSEL_MEM;
        else if (wb_hit)
            sel = OPSEL_WB;
        else
            sel = OPSEL_RF;
    end

    // Guard checks on the select leaving this module.
    always_comb begin
        if (!$isunknown(sel)) begin
            assert_sel_legal_R1: assert ($onehot0(sel))
                else $error("operand select drove 2'b11");
            if (sel == OPSEL_MEM) begin
                assert_mem_fwd_ok_R5: assert (mem_dst != ZERO_REG && !mem_is_load && mem_wr_en)
                    else $error("illegal execute/memory forward");
            end
            if (sel == OPSEL_WB) begin
                assert_wb_fwd_ok_R3: assert (wb_dst != ZERO_REG && wb_wr_en)
                    else $error("illegal write-back forward");
            end
        end
    end
endmodule

// File: rtl/load_use_detect.sv
// Detects a load in execute whose result the decode instruction needs next.
// Assumes store data can be fed later from write-back, so a store whose only
// dependence is its data source does not stall.
module load_use_detect #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic          id_use_a,
    input  logic          id_use_b,
    input  logic          id_is_store,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr_en,
    input  logic          ex_is_load,
    output logic          stall
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic pending_load;
    logic dep_a;
    logic dep_b;

    // Qualify the execute-stage producer as a load with a real destination.
    always_comb pending_load = ex_is_load && ex_wr_en && (ex_dst != ZERO_REG);

    // Per-source dependence; store data is excused from the interlock.
    always_comb begin
        dep_a = id_use_a && (id_src_a == ex_dst);
        dep_b = id_use_b && (id_src_b == ex_dst) && !id_is_store;
    end

    // Single-cycle interlock request.
    always_comb stall = pending_load && (dep_a || dep_b);

    // A stall is only ever caused by a load.
    always_comb begin
        if (!$isunknown(stall) && stall) begin
            assert_stall_cause_R7: assert (ex_is_load && ex_dst != ZERO_REG)
                else $error("stall without a load producer");
        end
    end
endmodule

// File: rtl/store_data_fwd.sv
// Memory-stage store-data bypass from the write-back value.
// Assumes the memory stage keeps the store's data source register number.
module store_data_fwd #(
    parameter int AW = 5
) (
    input  logic          mem_is_store,
    input  logic [AW-1:0] mem_src_b,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_en,
    output logic          fwd
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    // Bypass when the write-back stage produces the register being stored.
    always_comb fwd = mem_is_store && wb_wr_en && (wb_dst != ZERO_REG) && (wb_dst == mem_src_b);

    // The bypass never serves a non-store or register 0.
    always_comb begin
        if (!$isunknown(fwd) && fwd) begin
            assert_store_fwd_ok_R10: assert (mem_is_store && wb_dst != ZERO_REG)
                else $error("store bypass without store or with register 0");
        end
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
// Top of the forwarding and load-use interlock logic for a five-stage in-order pipeline.
// Purely combinational. Assumes the register file writes before it reads in the same cycle.
module hazard_fwd_unit #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic          id_use_a,
    input  logic          id_use_b,
    input  logic          id_is_store,
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr_en,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_en,
    input  logic          mem_is_load,
    input  logic          mem_is_store,
    input  logic [AW-1:0] mem_src_b,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_en,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic          store_fwd_wb,
    output logic          hold_front,
    output logic          bubble_idex
);
    localparam int NUM_OPS = 2;

    logic [AW-1:0] op_src [NUM_OPS];
    logic [1:0]    op_sel [NUM_OPS];
    logic          interlock;

    // Gather the execute-stage sources into an indexable array.
    always_comb begin
        op_src[0] = ex_src_a;
        op_src[1] = ex_src_b;
    end

    // One independent select per ALU operand.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_operand_sel #(.AW(AW)) u_sel (
            .src        (op_src[g]),
            .mem_dst    (mem_dst),
            .mem_wr_en  (mem_wr_en),
            .mem_is_load(mem_is_load),
            .wb_dst     (wb_dst),
            .wb_wr_en   (wb_wr_en),
            .sel        (op_sel[g])
        );
    end

    load_use_detect #(.AW(AW)) u_lud (
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .id_use_a   (id_use_a),
        .id_use_b   (id_use_b),
        .id_is_store(id_is_store),
        .ex_dst     (ex_dst),
        .ex_wr_en   (ex_wr_en),
        .ex_is_load (ex_is_load),
        .stall      (interlock)
    );

    store_data_fwd #(.AW(AW)) u_sdf (
        .mem_is_store(mem_is_store),
        .mem_src_b   (mem_src_b),
        .wb_dst      (wb_dst),
        .wb_wr_en    (wb_wr_en),
        .fwd         (store_fwd_wb)
    );

    // Drive the outputs from the sub-blocks.
    always_comb begin
        fwd_sel_a   = op_sel[0];
        fwd_sel_b   = op_sel[1];
        hold_front  = interlock;
        bubble_idex = interlock;
    end
endmodule

// File: tb/test_hazard_fwd_unit.sv
// Directed bench: each task drives one scenario and checks its own results.
module test_hazard_fwd_unit;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, mem_src_b, wb_dst;
    logic id_use_a, id_use_b, id_is_store, ex_wr_en, ex_is_load;
    logic mem_wr_en, mem_is_load, mem_is_store, wb_wr_en;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic store_fwd_wb, hold_front, bubble_idex;

    int n_checks = 0;
    int n_errors = 0;

    hazard_fwd_unit #(.AW(AW)) i_hazard_fwd_unit (
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
        .id_is_store(id_is_store), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
        .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
        .mem_is_load(mem_is_load), .mem_is_store(mem_is_store), .mem_src_b(mem_src_b),
        .wb_dst(wb_dst), .wb_wr_en(wb_wr_en), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .store_fwd_wb(store_fwd_wb), .hold_front(hold_front), .bubble_idex(bubble_idex)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        id_src_a = '0; id_src_b = '0; id_use_a = 0; id_use_b = 0; id_is_store = 0;
        ex_src_a = '0; ex_src_b = '0; ex_dst = '0; ex_wr_en = 0; ex_is_load = 0;
        mem_dst = '0; mem_wr_en = 0; mem_is_load = 0; mem_is_store = 0; mem_src_b = '0;
        wb_dst = '0; wb_wr_en = 0;
    endtask

    // Drive on the falling edge; caller sets inputs after this, then settle().
    task automatic start();
        @(negedge clk);
        idle();
    endtask

    task automatic settle();
        #5;
    endtask

    task automatic t_idle();
        start(); settle();
        chk("R11 idle sel_a", {2'b0, fwd_sel_a}, 4'h0);
        chk("R11 idle sel_b", {2'b0, fwd_sel_b}, 4'h0);
        chk("R11 idle stall/bubble/store", {1'b0, hold_front, bubble_idex, store_fwd_wb}, 4'h0);
    endtask

    task automatic t_mem_fwd();
        start();
        ex_src_a = 5'd7; mem_dst = 5'd7; mem_wr_en = 1;
        settle();
        chk("R2 exmem fwd a", {2'b0, fwd_sel_a}, 4'h2);
        chk("R1 other operand rf", {2'b0, fwd_sel_b}, 4'h0);
        mem_wr_en = 0; #2;
        chk("R5 disabled write not forwarded", {2'b0, fwd_sel_a}, 4'h0);
    endtask

    task automatic t_wb_fwd();
        start();
        ex_src_b = 5'd12; wb_dst = 5'd12; wb_wr_en = 1;
        settle();
        chk("R3 memwb fwd b", {2'b0, fwd_sel_b}, 4'h1);
        chk("R11 same-cycle response", {2'b0, fwd_sel_a}, 4'h0);
    endtask

    task automatic t_priority();
        start();
        ex_src_a = 5'd3; mem_dst = 5'd3; mem_wr_en = 1; wb_dst = 5'd3; wb_wr_en = 1;
        settle();
        chk("R4 exmem wins", {2'b0, fwd_sel_a}, 4'h2);
        mem_is_load = 1; #2;
        chk("R4 pending load blocks older", {2'b0, fwd_sel_a}, 4'h0);
    endtask

    task automatic t_zero();
        start();
        ex_src_a = 5'd0; ex_src_b = 5'd0; mem_dst = 5'd0; mem_wr_en = 1; wb_dst = 5'd0; wb_wr_en = 1;
        id_src_a = 5'd0; id_use_a = 1; ex_dst = 5'd0; ex_wr_en = 1; ex_is_load = 1;
        mem_is_store = 1; mem_src_b = 5'd0;
        settle();
        chk("R5 r0 sel_a", {2'b0, fwd_sel_a}, 4'h0);
        chk("R5 r0 sel_b", {2'b0, fwd_sel_b}, 4'h0);
        chk("R5 r0 no stall/store fwd", {2'b0, hold_front, store_fwd_wb}, 4'h0);
    endtask

    task automatic t_both_ops();
        start();
        ex_src_a = 5'd4; ex_src_b = 5'd9; mem_dst = 5'd4; mem_wr_en = 1; wb_dst = 5'd9; wb_wr_en = 1;
        settle();
        chk("R6 sel_a from exmem", {2'b0, fwd_sel_a}, 4'h2);
        chk("R6 sel_b from memwb", {2'b0, fwd_sel_b}, 4'h1);
        ex_src_b = 5'd4; #2;
        chk("R6 both from exmem", {fwd_sel_a, fwd_sel_b}, 4'hA);
    endtask

    task automatic t_load_use();
        start();
        ex_dst = 5'd5; ex_wr_en = 1; ex_is_load = 1; id_src_b = 5'd5; id_use_b = 1;
        settle();
        chk("R7 load-use on b", {2'b0, hold_front, bubble_idex}, 4'h3);
        id_src_b = 5'd6; id_src_a = 5'd5; id_use_a = 1; #2;
        chk("R7 load-use on a", {2'b0, hold_front, bubble_idex}, 4'h3);
    endtask

    task automatic t_no_stall();
        start();
        ex_dst = 5'd5; ex_wr_en = 1; ex_is_load = 1; id_src_a = 5'd5; id_use_a = 0;
        settle();
        chk("R8 unused source", {2'b0, hold_front, bubble_idex}, 4'h0);
        id_use_a = 1; ex_is_load = 0; #2;
        chk("R8 producer not load", {2'b0, hold_front, bubble_idex}, 4'h0);
        ex_is_load = 1; ex_wr_en = 0; #2;
        chk("R8 load write disabled", {2'b0, hold_front, bubble_idex}, 4'h0);
    endtask

    task automatic t_store_exc();
        start();
        ex_dst = 5'd8; ex_wr_en = 1; ex_is_load = 1;
        id_is_store = 1; id_src_a = 5'd2; id_use_a = 1; id_src_b = 5'd8; id_use_b = 1;
        settle();
        chk("R9 store data dep no stall", {2'b0, hold_front, bubble_idex}, 4'h0);
        id_src_a = 5'd8; #2;
        chk("R9 store address dep stalls", {2'b0, hold_front, bubble_idex}, 4'h3);
    endtask

    task automatic t_store_fwd();
        start();
        mem_is_store = 1; mem_src_b = 5'd11; wb_dst = 5'd11; wb_wr_en = 1;
        settle();
        chk("R10 store bypass", {3'b0, store_fwd_wb}, 4'h1);
        mem_is_store = 0; #2;
        chk("R10 no bypass without store", {3'b0, store_fwd_wb}, 4'h0);
        mem_is_store = 1; wb_dst = 5'd10; #2;
        chk("R10 no bypass on mismatch", {3'b0, store_fwd_wb}, 4'h0);
    endtask

    initial begin
        idle();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_zero();
        t_both_ops();
        t_load_use();
        t_no_stall();
        t_store_exc();
        t_store_fwd();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule